// File: doc/BRIEF.md
# Active Priority Tracking Bank

This block records which interrupt preemption levels are active at a processor interface. When an interrupt is acknowledged, it takes the interrupt's 8-bit priority and sets one bit in a bank of 32-bit bitmap words. When the interrupt's priority is dropped, it clears the most urgent active bit, which is the one with the lowest level. A separate flag records an active non-maskable interrupt.

The parameter `PRE_BITS` gives the number of implemented preemption bits (5, 6 or 7). It sets the number of levels (2^PRE_BITS) and the number of words (one, two or four). The level is the upper `PRE_BITS` bits of the priority. The upper bits of the level select the word and its low five bits select the bit.

Software can read and write each word directly. An access to a word that is not implemented is flagged as an undefined access. The block also outputs the running priority and the NMI-active flag.

Top module: `prio_active_bank`

## Requirements
- R1: After reset every bitmap bit and the NMI flag are 0, and `run_prio` reads 0xFF.
- R2: An acknowledge with `ack_nmi`=0 sets the bit for level L = `ack_prio >> (8-PRE_BITS)`. That bit is bit L mod 32 of word L/32. The priority bits below the level are ignored. The bit is visible on the next cycle.
- R3: `run_prio` equals the lowest set level shifted left by (8-PRE_BITS), with zeros in the low bits. When no bit is set it equals 0xFF. It is combinational on the registered state.
- R4: A drop with the NMI flag clear clears the lowest set bit. A drop when nothing is active changes nothing.
- R5: An acknowledge with `ack_nmi`=1 sets the NMI flag and leaves the bitmaps unchanged. A drop while the flag is set clears only the flag.
- R6: A read returns the word's bitmap in `sw_rdata[31:0]`. Bits 62:32 read as 0. Bit 63 carries the NMI flag for word 0 and reads 0 for every other word.
- R7: A write to an implemented word loads `sw_wdata` into it. A write to word 0 also loads `sw_wnmi` into the NMI flag. The new value is visible on the next cycle.
- R8: A read or write with `sw_idx` >= 2^(PRE_BITS-5) raises `sw_undef` in the same cycle and returns `sw_rdata`=0. Such a write changes no state.
- R9: A write to an implemented word takes precedence: any acknowledge or drop in the same cycle is discarded.
- R10: When an acknowledge and a drop arrive in the same cycle, the drop acts on the old state first, and then the acknowledge is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_prio | input | 8 | Priority of the acknowledged interrupt |
| ack_nmi | input | 1 | The acknowledged interrupt is non-maskable |
| drop_valid | input | 1 | Priority drop strobe |
| sw_rd | input | 1 | Software read strobe |
| sw_wr | input | 1 | Software write strobe |
| sw_idx | input | 2 | Word index for software access |
| sw_wdata | input | 32 | Bitmap write data |
| sw_wnmi | input | 1 | NMI flag write data (word 0 only) |
| sw_rdata | output | 64 | Read data of the selected word |
| sw_undef | output | 1 | Access to an unimplemented word |
| run_prio | output | 8 | Running priority, 0xFF when idle |
| nmi_active | output | 1 | An NMI is active |

## Verification
The assertions assume that `rst_n` is low for at least one clock edge before the first strobe. They also assume that a strobe on any input is a single-cycle level that is sampled at the rising edge. They do not assume the strobes are mutually exclusive, so the stimulus combines acknowledge, drop and write in the same cycle, both in the directed cases and in a random phase. In that random phase, the word index covers both implemented and unimplemented words, and priorities cover the whole 8-bit range. This keeps every input inside the range the properties expect, while still exercising the precedence rules.

// File: rtl/prio_active_bank.sv
module prio_active_bank #(
  parameter int PRE_BITS = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ack_valid,
  input  logic [7:0]  ack_prio,
  input  logic        ack_nmi,
  input  logic        drop_valid,
  input  logic        sw_rd,
  input  logic        sw_wr,
  input  logic [1:0]  sw_idx,
  input  logic [31:0] sw_wdata,
  input  logic        sw_wnmi,
  output logic [63:0] sw_rdata,
  output logic        sw_undef,
  output logic [7:0]  run_prio,
  output logic        nmi_active
);
  localparam int NLVL   = 1 << PRE_BITS;
  localparam int NWORDS = NLVL / 32;
  localparam int SH     = 8 - PRE_BITS;

  logic [NLVL-1:0]     act, act_drop, act_nxt;
  logic                nmi_q;
  logic                idx_ok, wr_ok, any;
  logic [PRE_BITS-1:0] lead;

  assign idx_ok   = 32'(sw_idx) < NWORDS;
  assign wr_ok    = sw_wr && idx_ok;
  assign sw_undef = (sw_rd || sw_wr) && !idx_ok;

  always_comb begin
    lead = '0;
    any  = 1'b0;
    for (int i = NLVL - 1; i >= 0; i--) begin
      if (act[i]) begin
        lead = PRE_BITS'(i);
        any  = 1'b1;
      end
    end
  end

  assign run_prio   = any ? (8'(lead) << SH) : 8'hFF;
  assign nmi_active = nmi_q;

  assign act_drop = (drop_valid && !nmi_q)
                    ? (act & (act - {{(NLVL-1){1'b0}}, 1'b1})) : act;

  always_comb begin
    act_nxt = act_drop;
    if (ack_valid && !ack_nmi) act_nxt[ack_prio[7:SH]] = 1'b1;
  end

  always_comb begin
    sw_rdata = '0;
    for (int w = 0; w < NWORDS; w++)
      if (sw_idx == 2'(w)) sw_rdata[31:0] = act[w*32 +: 32];
    sw_rdata[63] = (sw_idx == 2'd0) && nmi_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act   <= '0;
      nmi_q <= 1'b0;
    end else if (wr_ok) begin
      for (int w = 0; w < NWORDS; w++)
        if (sw_idx == 2'(w)) act[w*32 +: 32] <= sw_wdata;
      if (sw_idx == 2'd0) nmi_q <= sw_wnmi;
    end else begin
      act   <= act_nxt;
      nmi_q <= (nmi_q && !drop_valid) || (ack_valid && ack_nmi);
    end
  end
endmodule

// File: rtl/prio_active_bank_chk.sv
module prio_active_bank_chk #(
  parameter int PRE_BITS = 7
) (
  input logic        clk,
  input logic        rst_n,
  input logic        ack_valid,
  input logic [7:0]  ack_prio,
  input logic        ack_nmi,
  input logic        drop_valid,
  input logic        sw_wr,
  input logic [1:0]  sw_idx,
  input logic        sw_wnmi,
  input logic [63:0] sw_rdata,
  input logic        sw_undef,
  input logic [7:0]  run_prio,
  input logic        nmi_active
);
  localparam int NWORDS = (1 << PRE_BITS) / 32;
  localparam int SH     = 8 - PRE_BITS;
  localparam logic [7:0] LOWMASK = 8'((1 << SH) - 1);

  logic wr_ok;
  assign wr_ok = sw_wr && (32'(sw_idx) < NWORDS);

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (run_prio == 8'hFF && !nmi_active)); // R1
  AST_ACK_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !ack_nmi && !wr_ok) |=> (run_prio <= ($past(ack_prio) & ~LOWMASK))); // R2
  AST_PRIO_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (run_prio != 8'hFF) |-> ((run_prio & LOWMASK) == 8'h00)); // R3
  AST_EMPTY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_prio == 8'hFF && !nmi_active && !ack_valid && !wr_ok) |=> (run_prio == 8'hFF)); // R4
  AST_NMI_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_valid && nmi_active && !wr_ok && !(ack_valid && ack_nmi)) |=> !nmi_active); // R5
  AST_NMI_KEEPS_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_nmi && !drop_valid && !wr_ok) |=> $stable(run_prio)); // R5
  AST_RES0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rdata[62:32] == 31'd0); // R6
  AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sw_undef |-> (sw_rdata == 64'd0)); // R8
  AST_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && sw_idx == 2'd0) |=> (nmi_active == $past(sw_wnmi))); // R9
endmodule

bind prio_active_bank prio_active_bank_chk #(.PRE_BITS(PRE_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_valid(ack_valid), .ack_prio(ack_prio),
  .ack_nmi(ack_nmi), .drop_valid(drop_valid), .sw_wr(sw_wr), .sw_idx(sw_idx),
  .sw_wnmi(sw_wnmi), .sw_rdata(sw_rdata), .sw_undef(sw_undef),
  .run_prio(run_prio), .nmi_active(nmi_active)
);

// File: tb/sim_prio_active_bank.sv
module sim_prio_active_bank;
  localparam int CLK_P = 10;
  localparam int PB    = 6;
  localparam int NL    = 1 << PB;
  localparam int NW    = NL / 32;
  localparam int SHF   = 8 - PB;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ack_valid = 0, ack_nmi = 0, drop_valid = 0, sw_rd = 0, sw_wr = 0, sw_wnmi = 0;
  logic [7:0] ack_prio = 0;
  logic [1:0] sw_idx = 0;
  logic [31:0] sw_wdata = 0;
  logic [63:0] sw_rdata;
  logic sw_undef, nmi_active;
  logic [7:0] run_prio;

  int compared = 0, mismatched = 0;
  bit done = 0;
  bit lv [NL];
  bit mnmi = 0;

  always #(CLK_P/2) clk = ~clk;

  prio_active_bank #(.PRE_BITS(PB)) u0 (
    .clk(clk), .rst_n(rst_n), .ack_valid(ack_valid), .ack_prio(ack_prio),
    .ack_nmi(ack_nmi), .drop_valid(drop_valid), .sw_rd(sw_rd), .sw_wr(sw_wr),
    .sw_idx(sw_idx), .sw_wdata(sw_wdata), .sw_wnmi(sw_wnmi),
    .sw_rdata(sw_rdata), .sw_undef(sw_undef), .run_prio(run_prio),
    .nmi_active(nmi_active)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(string req);
    logic [7:0] er = 8'hFF;
    logic [63:0] ed = '0;
    for (int i = NL - 1; i >= 0; i--) if (lv[i]) er = 8'(i << SHF);
    if (int'(sw_idx) < NW) begin
      for (int b = 0; b < 32; b++) ed[b] = lv[int'(sw_idx)*32 + b];
      ed[63] = (sw_idx == 0) && mnmi;
    end
    chk(req, "run_prio (R3)", 64'(run_prio), 64'(er));
    chk(req, "nmi_active (R5)", 64'(nmi_active), 64'(mnmi));
    chk(req, "sw_rdata (R6)", sw_rdata, ed);
    chk(req, "sw_undef (R8)", 64'(sw_undef), 64'(((sw_rd || sw_wr) && int'(sw_idx) >= NW)));
  endtask

  task automatic step(string req, bit av, logic [7:0] ap, bit an, bit dv,
                      bit rd, bit wr, logic [1:0] idx, logic [31:0] wd, bit wn);
    ack_valid = av; ack_prio = ap; ack_nmi = an; drop_valid = dv;
    sw_rd = rd; sw_wr = wr; sw_idx = idx; sw_wdata = wd; sw_wnmi = wn;
    #1;
    compare_all(req);
    @(posedge clk);
    if (wr && int'(idx) < NW) begin
      for (int b = 0; b < 32; b++) lv[int'(idx)*32 + b] = wd[b];
      if (idx == 0) mnmi = wn;
    end else begin
      if (dv) begin
        if (mnmi) mnmi = 0;
        else begin
          for (int i = 0; i < NL; i++) if (lv[i]) begin lv[i] = 0; break; end
        end
      end
      if (av && an) mnmi = 1;
      if (av && !an) lv[int'(ap) >> SHF] = 1;
    end
    @(negedge clk);
  endtask

  task automatic rd_w(string req, logic [1:0] idx);
    step(req, 0, 0, 0, 0, 1, 0, idx, 0, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd_w("R1 reset word0", 0);
    rd_w("R1 reset word1", 1);
    step("R2 ack 0x80", 1, 8'h80, 0, 0, 0, 0, 0, 0, 0);
    rd_w("R2 word1 bit0", 1);
    step("R3 ack 0x14", 1, 8'h14, 0, 0, 0, 0, 0, 0, 0);
    step("R2 ack 0x17 same level", 1, 8'h17, 0, 0, 1, 0, 0, 0, 0);
    step("R4 drop lowest", 0, 0, 0, 1, 1, 0, 0, 0, 0);
    step("R10 ack+drop", 1, 8'h40, 0, 1, 1, 0, 1, 0, 0);
    rd_w("R10 check", 0);
    step("R5 nmi ack", 1, 8'h00, 1, 0, 1, 0, 0, 0, 0);
    rd_w("R5 nmi read", 0);
    step("R5 nmi drop", 0, 0, 0, 1, 1, 0, 0, 0, 0);
    rd_w("R5 after drop", 0);
    step("R7 write word1", 0, 0, 0, 0, 0, 1, 1, 32'h8000_0001, 1);
    rd_w("R7 word1 read", 1);
    rd_w("R6 word0 bit63 low", 0);
    step("R9 write wins", 1, 8'h04, 0, 1, 0, 1, 0, 32'h0000_0100, 1);
    rd_w("R9 word0 read", 0);
    step("R8 read word2", 0, 0, 0, 0, 1, 0, 2, 0, 0);
    step("R8 write word3", 0, 0, 0, 0, 0, 1, 3, 32'hFFFF_FFFF, 0);
    rd_w("R8 no effect w0", 0);
    rd_w("R8 no effect w1", 1);
    for (int k = 0; k < 6; k++) step("R4 drain", 0, 0, 0, 1, 0, 0, 0, 0, 0);
    step("R4 empty drop", 0, 0, 0, 1, 1, 0, 0, 0, 0);
    rd_w("R4 still empty", 0);
    for (int k = 0; k < 600; k++) begin
      logic [31:0] r = $urandom;
      step("R2 R4 R9 R10 random", r[0], 8'($urandom), r[1] & r[2] & r[3],
           r[4] & r[5], r[6], r[7] & r[8] & r[9], r[11:10],
           $urandom & $urandom, r[12]);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule